// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out the "set vector length" operation of a variable-length vector engine that runs on top of the scalar register files. Each accepted request brings the decoded fields: a 7-bit immediate, three mode flags, a record flag, and two flags that say whether the source and target register numbers are register zero. It also brings the source operand, the count register and the current 64-bit vector state word.

From these the unit computes a new maximum vector length (MVL) and a new vector length (VL). VL can be kept from the state word, taken from the source operand, taken from the immediate plus one, or taken from the count register. Values wider than 7 bits saturate to 127, and a VL above the new MVL is clamped down to MVL. Either event raises an overflow flag.

The unit returns the rewritten state word, VL zero-extended for the target register with its write enable, and a condition nibble when recording is requested. Results are registered and appear one cycle after the request, marked by a valid strobe.

Top module: `vlcfg_unit`

## Requirements
- R1: `outValid` is high exactly one cycle after `inValid`. While `inValid` is low, `mvlOut`, `vlOut`, `stateOut`, `rtData` and `crField` keep their values, and `rtWrEn` and `crWrEn` are low the next cycle. Reset clears every output to zero.
- R2: With `msFlag`=1, the new MVL is (`immField`+1) mod 128, so an immediate of 127 gives 0. With `msFlag`=0, MVL is `stateIn[63:57]`.
- R3: With `vsFlag`=0, VL before clamping is `stateIn[56:50]`, and no overflow comes from the source.
- R4: With `vsFlag`=1 and `raIsZero`=0, VL before clamping is `raValue`. If `raValue` is unsigned above 127, VL becomes 127 and overflow is set.
- R5: With `vsFlag`=1, `raIsZero`=1 and `rtIsZero`=1, VL before clamping is (`immField`+1) mod 128.
- R6: With `vsFlag`=1, `raIsZero`=1 and `rtIsZero`=0, VL before clamping is `ctrValue`. If `ctrValue` is unsigned above 127, VL becomes 127 and overflow is set.
- R7: If VL before clamping is unsigned above the new MVL, the final VL equals MVL and overflow is set.
- R8: `stateOut` equals `stateIn` except as follows. Bits [63:57] hold the new MVL and bits [56:50] hold the final VL. When `msFlag`=1, bit 0 takes `vfFlag` and bit 1 is cleared; when `msFlag`=0, bits 1 and 0 pass through.
- R9: `rtWrEn` is the inverse of `rtIsZero` for the request. `rtData` is the final VL zero-extended to 64 bits.
- R10: `crWrEn` copies `rcFlag`. When it is set, `crField` is {bit3 LT=0, bit2 GT=(VL≠0), bit1 EQ=(VL=0), bit0 SO=overflow}. When `rcFlag`=0, `crField` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| immField | input | 7 | Immediate operand |
| msFlag | input | 1 | Set MVL from the immediate |
| vsFlag | input | 1 | Set VL from the selected source |
| vfFlag | input | 1 | Mode bit written when msFlag is set |
| rcFlag | input | 1 | Request a condition nibble |
| raIsZero | input | 1 | Source register number is zero |
| rtIsZero | input | 1 | Target register number is zero |
| raValue | input | 64 | Source register operand |
| ctrValue | input | 64 | Count register value |
| stateIn | input | 64 | Current vector state word |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| mvlOut | output | 7 | New maximum vector length |
| vlOut | output | 7 | New vector length |
| stateOut | output | 64 | Rewritten vector state word |
| rtWrEn | output | 1 | Target register write enable |
| rtData | output | 64 | Zero-extended VL for the target register |
| crWrEn | output | 1 | Condition nibble write enable |
| crField | output | 4 | LT, GT, EQ, SO condition nibble |

## Verification
On every request the assertions check several invariants. The final VL never exceeds MVL. The state fields mirror the MVL and VL outputs, and the target data keeps its upper bits at zero. EQ and GT are mutually exclusive, a kept MVL equals the one held in the state word, and an oversized source operand raises SO. Other properties cannot be stated per cycle, and only the bench's sweep over every flag combination, boundary immediates, saturating operands and clamping state words shows them. These are the exact source priority between register, immediate and count, the wrap of immediate 127 to zero, the pass-through of untouched state bits, and holding outputs between requests.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_REG  = 2'd1,
    SRC_IMM  = 2'd2,
    SRC_CTR  = 2'd3
  } vlSrc_e;

  typedef struct packed {
    logic   setMvl;
    vlSrc_e vlSrc;
    logic   writeRt;
    logic   writeCr;
    logic   setMode;
  } ctrlStrobes_t;

endpackage

// File: rtl/vlcfg_sat.sv
module vlcfg_sat #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic [XLEN-1:0]  value,
  output logic [LEN_W-1:0] result,
  output logic             ovf
);
  // any set bit above the length field means the value cannot fit
  always_comb begin
    ovf    = |value[XLEN-1:LEN_W];
    result = ovf ? {LEN_W{1'b1}} : value[LEN_W-1:0];
  end
endmodule

// File: rtl/vlcfg_ctrl.sv
module vlcfg_ctrl
  import vlcfg_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         msFlag,
  input  logic         vsFlag,
  input  logic         rcFlag,
  input  logic         raIsZero,
  input  logic         rtIsZero,
  output ctrlStrobes_t strb,
  output logic         outValid,
  output logic         rtWrEn,
  output logic         crWrEn
);

  always_comb begin
    strb.setMvl  = msFlag;
    strb.setMode = msFlag;
    strb.writeRt = !rtIsZero;
    strb.writeCr = rcFlag;
    if (!vsFlag)        strb.vlSrc = SRC_KEEP;
    else if (!raIsZero) strb.vlSrc = SRC_REG;
    else if (rtIsZero)  strb.vlSrc = SRC_IMM;
    else                strb.vlSrc = SRC_CTR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      rtWrEn   <= 1'b0;
      crWrEn   <= 1'b0;
    end else begin
      outValid <= inValid;
      rtWrEn   <= inValid && strb.writeRt;
      crWrEn   <= inValid && strb.writeCr;
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && !rtWrEn && !crWrEn));
  assert_rt_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (rtWrEn == !$past(rtIsZero)));

endmodule

// File: rtl/vlcfg_dpath.sv
module vlcfg_dpath
  import vlcfg_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  ctrlStrobes_t     strb,
  input  logic [LEN_W-1:0] immField,
  input  logic             vfFlag,
  input  logic [XLEN-1:0]  raValue,
  input  logic [XLEN-1:0]  ctrValue,
  input  logic [XLEN-1:0]  stateIn,
  output logic [LEN_W-1:0] mvlOut,
  output logic [LEN_W-1:0] vlOut,
  output logic [XLEN-1:0]  stateOut,
  output logic [XLEN-1:0]  rtData,
  output logic [3:0]       crField
);
  // MSB-first bit k sits at LSB-first position XLEN-1-k
  localparam int MVL_LO      = XLEN - LEN_W;
  localparam int VL_LO       = XLEN - 2 * LEN_W;
  localparam int MODE_POS    = 0;
  localparam int PERSIST_POS = 1;
  localparam int NUM_SAT     = 2;

  logic [XLEN-1:0]  satIn  [NUM_SAT];
  logic [LEN_W-1:0] satRes [NUM_SAT];
  logic             satOvf [NUM_SAT];

  assign satIn[0] = raValue;
  assign satIn[1] = ctrValue;

  for (genvar g = 0; g < NUM_SAT; g++) begin : g_sat
    vlcfg_sat #(.XLEN(XLEN), .LEN_W(LEN_W)) u_sat (
      .value  (satIn[g]),
      .result (satRes[g]),
      .ovf    (satOvf[g])
    );
  end

  logic [LEN_W-1:0] immInc, mvlNext, vlRaw, vlNext;
  logic             srcOvf, clampHit, ovfNext;
  logic [XLEN-1:0]  stateNext;
  logic [3:0]       crNext;

  always_comb begin
    immInc  = immField + LEN_W'(1);
    mvlNext = strb.setMvl ? immInc : stateIn[MVL_LO +: LEN_W];
    unique case (strb.vlSrc)
      SRC_KEEP: begin vlRaw = stateIn[VL_LO +: LEN_W]; srcOvf = 1'b0;      end
      SRC_REG:  begin vlRaw = satRes[0];               srcOvf = satOvf[0]; end
      SRC_IMM:  begin vlRaw = immInc;                  srcOvf = 1'b0;      end
      default:  begin vlRaw = satRes[1];               srcOvf = satOvf[1]; end
    endcase
    clampHit = vlRaw > mvlNext;
    vlNext   = clampHit ? mvlNext : vlRaw;
    ovfNext  = srcOvf | clampHit;

    stateNext = stateIn;
    stateNext[MVL_LO +: LEN_W] = mvlNext;
    stateNext[VL_LO +: LEN_W]  = vlNext;
    if (strb.setMode) begin
      stateNext[MODE_POS]    = vfFlag;
      stateNext[PERSIST_POS] = 1'b0;
    end

    crNext = strb.writeCr ? {1'b0, vlNext != '0, vlNext == '0, ovfNext} : 4'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mvlOut   <= '0;
      vlOut    <= '0;
      stateOut <= '0;
      rtData   <= '0;
      crField  <= '0;
    end else if (load) begin
      mvlOut   <= mvlNext;
      vlOut    <= vlNext;
      stateOut <= stateNext;
      rtData   <= {{(XLEN-LEN_W){1'b0}}, vlNext};
      crField  <= crNext;
    end
  end

  assert_vl_within_mvl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (vlOut <= mvlOut));
  assert_mvl_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !strb.setMvl) |=> (mvlOut == $past(stateIn[MVL_LO +: LEN_W])));
  assert_state_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (stateOut[MVL_LO +: LEN_W] == mvlOut && stateOut[VL_LO +: LEN_W] == vlOut));
  assert_reg_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && strb.vlSrc == SRC_REG && strb.writeCr && (|raValue[XLEN-1:LEN_W])) |=> crField[0]);
  assert_rt_zext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rtData[XLEN-1:LEN_W] == '0 && rtData[LEN_W-1:0] == vlOut));
  assert_cr_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && strb.writeCr) |=> ((crField[1] ^ crField[2]) && !crField[3]));

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [LEN_W-1:0] immField,
  input  logic             msFlag,
  input  logic             vsFlag,
  input  logic             vfFlag,
  input  logic             rcFlag,
  input  logic             raIsZero,
  input  logic             rtIsZero,
  input  logic [XLEN-1:0]  raValue,
  input  logic [XLEN-1:0]  ctrValue,
  input  logic [XLEN-1:0]  stateIn,
  output logic             outValid,
  output logic [LEN_W-1:0] mvlOut,
  output logic [LEN_W-1:0] vlOut,
  output logic [XLEN-1:0]  stateOut,
  output logic             rtWrEn,
  output logic [XLEN-1:0]  rtData,
  output logic             crWrEn,
  output logic [3:0]       crField
);

  ctrlStrobes_t strb;

  vlcfg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .msFlag   (msFlag),
    .vsFlag   (vsFlag),
    .rcFlag   (rcFlag),
    .raIsZero (raIsZero),
    .rtIsZero (rtIsZero),
    .strb     (strb),
    .outValid (outValid),
    .rtWrEn   (rtWrEn),
    .crWrEn   (crWrEn)
  );

  vlcfg_dpath #(.XLEN(XLEN), .LEN_W(LEN_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (inValid),
    .strb     (strb),
    .immField (immField),
    .vfFlag   (vfFlag),
    .raValue  (raValue),
    .ctrValue (ctrValue),
    .stateIn  (stateIn),
    .mvlOut   (mvlOut),
    .vlOut    (vlOut),
    .stateOut (stateOut),
    .rtData   (rtData),
    .crField  (crField)
  );

endmodule

// File: tb/sim_vlcfg_unit.sv
module sim_vlcfg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [6:0]  immField = '0;
  logic        msFlag = 1'b0, vsFlag = 1'b0, vfFlag = 1'b0, rcFlag = 1'b0;
  logic        raIsZero = 1'b0, rtIsZero = 1'b0;
  logic [63:0] raValue = '0, ctrValue = '0, stateIn = '0;
  logic        outValid, rtWrEn, crWrEn;
  logic [6:0]  mvlOut, vlOut;
  logic [63:0] stateOut, rtData;
  logic [3:0]  crField;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  vlcfg_unit u0 (.*);

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  longint unsigned immVals [6] = '{0, 1, 5, 63, 126, 127};
  longint unsigned opVals  [5] = '{0, 5, 127, 128, 64'hFFFF_0000_0000_0003};
  longint unsigned stMvl   [4] = '{0, 64, 20, 127};
  longint unsigned stVl    [4] = '{0, 10, 90, 127};
  longint unsigned stLow   [4] = '{64'h0, 64'h2_5A5A_1234_5677,
                                   64'h1_0F0F_F0F0_0001, 64'h3_FFFF_FFFF_FFFE};

  // expected outputs of the most recent accepted request
  logic [6:0]  eMvl, eVl;
  logic [63:0] eState, eRt;
  logic [3:0]  eCr;

  initial begin : main
    // reset state, R1
    repeat (3) @(negedge clk);
    check("R1", "reset outValid", 64'(outValid), 64'd0);
    check("R1", "reset mvlOut", 64'(mvlOut), 64'd0);
    check("R1", "reset stateOut", stateOut, 64'd0);
    check("R1", "reset crField", 64'(crField), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int f = 0; f < 64; f++) begin
      for (int ii = 0; ii < 6; ii++) begin
        for (int vi = 0; vi < 5; vi++) begin
          for (int si = 0; si < 4; si++) begin
            longint unsigned imm, ra, ctr, st, immInc, mvl, vlr;
            logic ovf;
            string vlReq;
            imm = immVals[ii];
            ra  = opVals[vi];
            ctr = opVals[4 - vi];
            st  = (stMvl[si] << 57) | (stVl[si] << 50) | stLow[si];
            msFlag   = f[0]; vsFlag   = f[1]; vfFlag = f[2];
            rcFlag   = f[3]; raIsZero = f[4]; rtIsZero = f[5];
            immField = imm[6:0]; raValue = ra; ctrValue = ctr; stateIn = st;
            inValid  = 1'b1;

            immInc = (imm + 1) & 127;
            mvl = msFlag ? immInc : ((st >> 57) & 127);
            ovf = 1'b0;
            if (!vsFlag) begin
              vlr = (st >> 50) & 127; vlReq = "R3";
            end else if (!raIsZero) begin
              vlReq = "R4";
              if (ra > 127) begin vlr = 127; ovf = 1'b1; end else vlr = ra;
            end else if (rtIsZero) begin
              vlr = immInc; vlReq = "R5";
            end else begin
              vlReq = "R6";
              if (ctr > 127) begin vlr = 127; ovf = 1'b1; end else vlr = ctr;
            end
            if (vlr > mvl) begin vlr = mvl; ovf = 1'b1; vlReq = "R7"; end
            eMvl = mvl[6:0];
            eVl  = vlr[6:0];
            eState = (st & ~(64'h7F << 57) & ~(64'h7F << 50)) | (mvl << 57) | (vlr << 50);
            if (msFlag) eState = (eState & ~64'h3) | 64'(vfFlag);
            eRt = 64'(eVl);
            eCr = rcFlag ? {1'b0, eVl != 0, eVl == 0, ovf} : 4'b0;

            @(negedge clk);
            check("R1", "outValid", 64'(outValid), 64'd1);
            check("R2", "mvlOut", 64'(mvlOut), 64'(eMvl));
            check(vlReq, "vlOut", 64'(vlOut), 64'(eVl));
            check("R8", "stateOut", stateOut, eState);
            check("R9", "rtWrEn", 64'(rtWrEn), 64'(!rtIsZero));
            check("R9", "rtData", rtData, eRt);
            check("R10", "crWrEn", 64'(crWrEn), 64'(rcFlag));
            check("R10", "crField", 64'(crField), 64'(eCr));

            // idle cycle with scrambled inputs: outputs must hold, R1
            inValid = 1'b0;
            immField = ~immField; msFlag = ~msFlag; vsFlag = ~vsFlag;
            raValue = ~raValue; ctrValue = ~ctrValue; stateIn = ~stateIn;
            rcFlag = 1'b1; rtIsZero = 1'b0;
            @(negedge clk);
            check("R1", "idle outValid", 64'(outValid), 64'd0);
            check("R1", "idle enables", {62'd0, rtWrEn, crWrEn}, 64'd0);
            check("R1", "hold vlOut", 64'(vlOut), 64'(eVl));
            check("R1", "hold stateOut", stateOut, eState);
            check("R1", "hold crField", 64'(crField), 64'(eCr));
          end
        end
      end
    end
    finished = 1;
  end

  initial begin : watchdog
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule